// File: doc/BRIEF.md
# Per-Core Banked Timer Aggregator

The block holds one private down-counting timer per core for a configurable number of cores. All of them sit behind a single register port. The port's address space is cut into 32-byte windows. Window 0 is a shared alias: an access there reaches the timer that belongs to the core named on the `bus_core` input. Every later window is wired to one fixed core, so any core can also inspect or program a neighbour's timer.

The block checks each access before it reaches a timer. A byte-enable pattern other than a full 32-bit word is rejected. An alias access whose core ID is not below the configured core count is also rejected. A rejected access leaves every timer untouched, reads as zero and raises `bus_err` in the same cycle. Windows whose core index is at or above the configured count, and addresses past the last window, are silent holes: they read as zero and drop writes. Each timer drives its own interrupt line, and one reset clears every instance. A core count outside 1..`MAX_CORES` stops elaboration.

Top module: `core_timer_bank`

## Requirements
- R1: The window index is `bus_addr[ADDR_W-1:5]`. Window 0 is the alias, and window n+1 reaches core n. Inside a window, byte offset 0x0 is the reload value, 0x4 the live count, 0x8 the control word and 0xC the status word. Offsets 0x10 to 0x1C read as zero.
- R2: An access to window 0 with a valid core ID reaches the timer of core `bus_core` and no other.
- R3: An access to window 0 with `bus_core` >= NUM_CORES changes no timer, returns zero on a read, and drives `bus_err` high while `bus_valid` is high.
- R4: An access whose `bus_be` is not 4'hF changes no timer, reads as zero and drives `bus_err` high.
- R5: A window for a core index >= NUM_CORES, or any window past window MAX_CORES, reads zero, drops writes and leaves `bus_err` low.
- R6: While `rst_n` is low, every timer's reload, count, control and status is zero and every interrupt line is low.
- R7: Control bit 0 enables counting, bit 1 selects auto-reload, bit 2 enables the interrupt, and bits 15:8 are a prescale P. An enabled timer decrements its count once every P+1 cycles, counting from the control write.
- R8: When a tick takes the count from 1 to 0, status bit 0 is set. In one-shot mode the count then stays at 0. In reload mode the count takes the reload value instead of 0.
- R9: Writing 1 to status bit 0 clears it. `core_irq[i]` equals core i's status bit 0 ANDed with its interrupt-enable bit, with bit 0 belonging to core 0.
- R10: Writing the reload register loads both the reload value and the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, fanned out to every timer |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address (window index and offset) |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_core | input | ID_W | ID of the requesting core, used by window 0 |
| bus_rdata | output | 32 | Combinational read data |
| bus_err | output | 1 | Rejected-access flag, valid while bus_valid is high |
| core_irq | output | NUM_CORES | Interrupt line per core, core 0 in bit 0 |

## Verification
A wrong routing decision shows up within a single access. A read through the alias returns a neighbour's reload value, and a write lands in the wrong core and is visible on the next read through the fixed windows. The bench therefore cross-reads every core through both paths after each sweep. A wrong prescale or reload state shows up as a count off by one in a read taken on any cycle of the run, or as an interrupt edge one cycle early or late. For this reason the count is compared on every cycle against an arithmetic formula.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam int WIN_OFF_W = 5;   // 32-byte windows
  localparam int PRE_W     = 8;

  // word index inside a window
  localparam logic [2:0] REG_LOAD  = 3'd0;
  localparam logic [2:0] REG_COUNT = 3'd1;
  localparam logic [2:0] REG_CTRL  = 3'd2;
  localparam logic [2:0] REG_STAT  = 3'd3;

  // control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_RLD  = 1;
  localparam int CB_IEN  = 2;
  localparam int CB_PRE  = 8;

  // core a window points at: window 0 follows the requester
  function automatic int map_target(input int win, input int core_id);
    return (win == 0) ? core_id : win - 1;
  endfunction

  // next count value on a tick
  function automatic logic [31:0] next_count(input logic [31:0] cnt,
                                             input logic [31:0] rld_val,
                                             input logic        rld_mode);
    if (cnt == 32'd0) return 32'd0;
    if (cnt == 32'd1) return rld_mode ? rld_val : 32'd0;
    return cnt - 32'd1;
  endfunction
endpackage

// File: rtl/ctb_window_decode.sv
module ctb_window_decode
  import ctb_pkg::*;
#(
  parameter int MAX_CORES = 4,
  parameter int NUM_CORES = 2,
  parameter int IDX_W     = 3,
  parameter int ID_W      = 3,
  localparam int ADDR_W   = IDX_W + WIN_OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [3:0]           be,
  input  logic [ID_W-1:0]      core_id,
  output logic [NUM_CORES-1:0] sel,
  output logic [2:0]           word_idx,
  output logic                 err
);
  logic [IDX_W-1:0] win;
  logic             is_alias;
  logic             size_ok;
  logic             alias_bad;
  int               target;

  assign win       = addr[ADDR_W-1:WIN_OFF_W];
  assign word_idx  = addr[4:2];
  assign is_alias  = (win == '0);
  assign size_ok   = (be == 4'hF);
  assign alias_bad = is_alias && (int'(core_id) >= NUM_CORES);
  assign target    = map_target(int'(win), int'(core_id));
  assign err       = valid && (!size_ok || alias_bad);

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_sel
    assign sel[i] = valid && size_ok && !alias_bad && (target == i);
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R2
  AST_ERR_BLOCKS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (sel == '0)); // R3
  AST_BADSIZE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && be != 4'hF) |-> (sel == '0)); // R4
endmodule

// File: rtl/ctb_core_timer.sv
module ctb_core_timer
  import ctb_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  word_idx,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  logic [CNT_W-1:0] load_q, count_q;
  logic [PRE_W-1:0] pre_q, pre_cnt_q;
  logic             en_q, rld_q, ien_q, stat_q;

  logic wr_load, wr_count, wr_ctrl, wr_stat;
  logic tick_evt, zero_evt, cnt_wr;

  assign wr_load  = wr_en && (word_idx == REG_LOAD);
  assign wr_count = wr_en && (word_idx == REG_COUNT);
  assign wr_ctrl  = wr_en && (word_idx == REG_CTRL);
  assign wr_stat  = wr_en && (word_idx == REG_STAT);
  assign cnt_wr   = wr_load || wr_count;
  assign tick_evt = en_q && (pre_cnt_q == '0) && !cnt_wr;
  assign zero_evt = tick_evt && (count_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q    <= '0;
      count_q   <= '0;
      pre_q     <= '0;
      pre_cnt_q <= '0;
      en_q      <= 1'b0;
      rld_q     <= 1'b0;
      ien_q     <= 1'b0;
      stat_q    <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata[CNT_W-1:0];
      if (cnt_wr)
        count_q <= wdata[CNT_W-1:0];
      else if (tick_evt)
        count_q <= CNT_W'(next_count(32'(count_q), 32'(load_q), rld_q));
      if (wr_ctrl) begin
        en_q      <= wdata[CB_EN];
        rld_q     <= wdata[CB_RLD];
        ien_q     <= wdata[CB_IEN];
        pre_q     <= wdata[CB_PRE +: PRE_W];
        pre_cnt_q <= wdata[CB_PRE +: PRE_W];
      end else if (en_q) begin
        pre_cnt_q <= (pre_cnt_q == '0) ? pre_q : pre_cnt_q - 1'b1;
      end
      stat_q <= (stat_q && !(wr_stat && wdata[0])) || zero_evt;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (word_idx)
      REG_LOAD:  rdata = 32'(load_q);
      REG_COUNT: rdata = 32'(count_q);
      REG_CTRL:  rdata = {16'd0, pre_q, 5'd0, ien_q, rld_q, en_q};
      REG_STAT:  rdata = {31'd0, stat_q};
      default:   rdata = '0;
    endcase
  end

  assign irq = stat_q && ien_q;

  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !rld_q && count_q == '0 && !wr_en) |=> (count_q == '0)); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !(wr_stat && wdata[0])) |=> stat_q); // R9
  AST_LOAD_SETS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (count_q == $past(wdata[CNT_W-1:0]) && load_q == count_q)); // R10
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> $stable(count_q)); // R7
endmodule

// File: rtl/core_timer_bank.sv
module core_timer_bank
  import ctb_pkg::*;
#(
  parameter int MAX_CORES = 4,
  parameter int NUM_CORES = 2,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = $clog2(MAX_CORES + 1),
  localparam int ID_W     = $clog2(MAX_CORES) + 1,
  localparam int ADDR_W   = IDX_W + WIN_OFF_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  input  logic [ID_W-1:0]      bus_core,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  output logic [NUM_CORES-1:0] core_irq
);
  if (NUM_CORES < 1 || NUM_CORES > MAX_CORES) begin : g_cfg_bad
    $error("core_timer_bank: NUM_CORES must lie in 1..MAX_CORES");
  end

  logic [NUM_CORES-1:0] sel;
  logic [2:0]           word_idx;
  logic [31:0]          core_rdata [NUM_CORES];

  ctb_window_decode #(
    .MAX_CORES(MAX_CORES), .NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .ID_W(ID_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .valid(bus_valid), .addr(bus_addr),
    .be(bus_be), .core_id(bus_core), .sel(sel), .word_idx(word_idx),
    .err(bus_err)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    ctb_core_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .wr_en(sel[i] && bus_write),
      .word_idx(word_idx), .wdata(bus_wdata), .rdata(core_rdata[i]),
      .irq(core_irq[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (sel[i] && !bus_write) bus_rdata |= core_rdata[i];
  end

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_err) |-> (bus_rdata == '0)); // R3
  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && sel == '0) |-> (bus_rdata == '0)); // R5
  AST_IRQ_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (core_irq == '0)); // R6
endmodule

// File: tb/core_timer_bank_test.sv
`timescale 1ns/1ps
module core_timer_bank_test;
  localparam int MAXC = 4;
  localparam int NC   = 2;
  localparam int AW   = 8;
  localparam int IW   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0]    bus_be = 4'hF;
  logic [31:0]   bus_wdata = '0;
  logic [IW-1:0] bus_core = '0;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic [NC-1:0] core_irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  core_timer_bank #(.MAX_CORES(MAXC), .NUM_CORES(NC), .CNT_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_core(bus_core), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .core_irq(core_irq)
  );

  function automatic logic [AW-1:0] adr(input int win, input int off);
    return AW'(win * 32 + off);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int win, input int off, input logic [31:0] d,
                        input int core, input logic [3:0] be, output logic err);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = adr(win, off);
    bus_wdata = d; bus_core = IW'(core); bus_be = be;
    #1 err = bus_err;
    @(posedge clk);
    #1 bus_valid = 0; bus_write = 0; bus_be = 4'hF;
  endtask

  task automatic bus_rd(input int win, input int off, input int core,
                        input logic [3:0] be, output logic [31:0] d, output logic err);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = adr(win, off);
    bus_core = IW'(core); bus_be = be;
    #1 d = bus_rdata; err = bus_err;
    bus_valid = 0; bus_be = 4'hF;
  endtask

  // periodic count after e cycles from the control write
  function automatic logic [31:0] per_count(input int ld, input int pre, input int e);
    int ticks = e / (pre + 1);
    return 32'(ld - (ticks % ld));
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    repeat (3) @(posedge clk);
    // R6: reset state
    check("R6 irq in reset", 32'(core_irq), 0);
    #1 rst_n = 1;
    for (int c = 0; c < NC; c++)
      for (int o = 0; o < 16; o += 4) begin
        bus_rd(c + 1, o, 0, 4'hF, d, e);
        check("R6 reg after reset", d, 0);
      end

    // R1 R10 R2: direct writes, cross-read through both paths
    for (int c = 0; c < NC; c++) begin
      bus_wr(c + 1, 0, 32'h1000 + 32'(c * 17), 0, 4'hF, e);
    end
    for (int c = 0; c < NC; c++) begin
      bus_rd(c + 1, 0, 0, 4'hF, d, e); check("R1 load direct", d, 32'h1000 + 32'(c * 17));
      bus_rd(c + 1, 4, 0, 4'hF, d, e); check("R10 count follows load", d, 32'h1000 + 32'(c * 17));
      bus_rd(0, 0, c, 4'hF, d, e);     check("R2 alias read", d, 32'h1000 + 32'(c * 17));
      for (int o = 16; o < 32; o += 4) begin
        bus_rd(c + 1, o, 0, 4'hF, d, e); check("R1 unused offset", d, 0);
      end
    end

    // R2 R3: alias writes for every ID
    for (int id = 0; id < 8; id++) begin
      bus_wr(0, 0, 32'h200 + 32'(id), id, 4'hF, e);
      check("R3 alias write err", 32'(e), (id >= NC) ? 1 : 0);
    end
    for (int c = 0; c < NC; c++) begin
      bus_rd(c + 1, 0, 0, 4'hF, d, e); check("R2 alias write landed", d, 32'h200 + 32'(c));
    end
    for (int id = 0; id < 8; id++) begin
      bus_rd(0, 0, id, 4'hF, d, e);
      check("R3 alias read data", d, (id >= NC) ? 0 : 32'h200 + 32'(id));
      check("R3 alias read err", 32'(e), (id >= NC) ? 1 : 0);
    end

    // R4: every partial byte-enable pattern
    for (int b = 0; b < 15; b++) begin
      bus_wr(1, 0, 32'hDEAD, 0, 4'(b), e); check("R4 write err", 32'(e), 1);
      bus_rd(1, 0, 0, 4'(b), d, e);       check("R4 read zero", d, 0);
      check("R4 read err", 32'(e), 1);
    end
    bus_rd(1, 0, 0, 4'hF, d, e); check("R4 core0 untouched", d, 32'h200);

    // R5: unpopulated and out-of-range windows
    for (int w = NC + 1; w < 8; w++) begin
      bus_wr(w, 0, 32'hBEEF, 0, 4'hF, e); check("R5 hole write err", 32'(e), 0);
      bus_rd(w, 0, 0, 4'hF, d, e);       check("R5 hole read", d, 0);
    end
    for (int c = 0; c < NC; c++) begin
      bus_rd(c + 1, 0, 0, 4'hF, d, e); check("R5 cores untouched", d, 32'h200 + 32'(c));
    end

    // R7 R8 R9: core 0 one-shot, prescale 0
    bus_wr(1, 0, 32'd10, 0, 4'hF, e);
    bus_wr(1, 8, 32'h5, 0, 4'hF, e);
    repeat (3) @(posedge clk);
    bus_rd(1, 4, 0, 4'hF, d, e); check("R7 count after 3", d, 7);
    repeat (6) @(posedge clk);
    #1 check("R9 irq before zero", 32'(core_irq), 0);
    @(posedge clk);
    #1 check("R8 irq at zero", 32'(core_irq), 1);
    repeat (5) @(posedge clk);
    bus_rd(1, 4, 0, 4'hF, d, e); check("R8 one-shot holds", d, 0);
    bus_rd(1, 12, 0, 4'hF, d, e); check("R8 status set", d, 1);
    bus_wr(1, 12, 32'h1, 0, 4'hF, e);
    #1 check("R9 irq cleared", 32'(core_irq), 0);
    bus_rd(1, 12, 0, 4'hF, d, e); check("R9 status cleared", d, 0);

    // R7 R8: core 1 through the alias, reload, prescale 2, every cycle
    bus_wr(0, 0, 32'd3, 1, 4'hF, e);
    bus_wr(0, 8, 32'h0207, 1, 4'hF, e);
    for (int k = 1; k <= 14; k++) begin
      @(posedge clk);
      bus_rd(2, 4, 0, 4'hF, d, e);
      check("R7 periodic count", d, per_count(3, 2, k));
      if (k == 8) check("R9 irq1 before wrap", 32'(core_irq), 0);
      if (k == 9) check("R8 irq1 at wrap", 32'(core_irq), 2);
    end

    // R6: reset mid-run clears everything
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R6 irq cleared by reset", 32'(core_irq), 0);
    rst_n = 1;
    for (int c = 0; c < NC; c++) begin
      bus_rd(c + 1, 0, 0, 4'hF, d, e); check("R6 load cleared", d, 0);
      bus_rd(c + 1, 8, 0, 4'hF, d, e); check("R6 ctrl cleared", d, 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule